// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the column path of a synchronous DRAM model or controller. Software-visible mode settings arrive as a 12-bit mode word: burst length, burst ordering, CAS latency, the single-beat-write option and the operation-mode bits. A read or write command supplies a starting column. From the clock edge that registers the command, the block produces one column address per cycle until the burst completes. The burst also ends early if a stop request arrives or a newer command replaces it.

Addresses stay inside the aligned block whose size is the burst length. Within that block they follow either an incrementing, wrapping order or an XOR (interleaved) order. A full-page setting walks the whole 256-column row endlessly, in incrementing order, until it is stopped or replaced. Alongside the address the block outputs a burst-active flag, a final-beat flag, the decoded CAS latency and a flag for illegal mode words.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The burst-length field is `mode_word[2:0]`. Code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. Code 111 with incrementing ordering selects full page. A new mode word takes effect on the cycle after the edge on which `mode_load` is sampled high.
- R2: `mode_word[3]` chooses the ordering: 0 is incrementing and 1 is interleaved.
- R3: `mode_word[6:4]` holds the CAS latency. Code 010 makes `cas_lat` read 2 and code 011 makes it read 3. After reset, `cas_lat` reads 2.
- R4: The following mode words are illegal:
  - a length code of 100, 101 or 110;
  - length code 111 together with interleaved ordering;
  - any latency code other than 010 or 011;
  - any of `mode_word[8:7]` or `mode_word[11:10]` set.

  An illegal word sets `mode_err`, forces the burst length to 1 and makes `cas_lat` read 3. A legal word clears `mode_err`.
- R5: In incrementing order with length L and start S, beat i has address (S - S mod L) + ((S mod L + i) mod L).
- R6: In interleaved order, beat i has address (S - S mod L) + ((S mod L) XOR i).
- R7: A full-page burst outputs (S + i) mod 256 on beat i. It never asserts `last_beat` and never ends by itself.
- R8: `last_beat` is high exactly during the final beat of a finite burst. If no command arrives, `burst_active` falls on the next cycle. While idle, `col_addr` is 0.
- R9: A command (`cmd_valid`) registered at any edge, including one during a running burst, starts a new full-length burst at `cmd_col` on the next cycle. A command takes priority over a stop request sampled at the same edge.
- R10: A stop request (`burst_stop`) sampled during a burst ends it, so `burst_active` is low on the next cycle.
- R11: When `mode_word[9]` is set, write commands (`cmd_write`=1) produce a single beat, while read commands keep the programmed length.
- R12: The length, ordering and single-write settings are captured when a command is registered. Loading a new mode word during a burst leaves that burst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load `mode_word` into the mode settings |
| mode_word | input | 12 | Mode word: length, ordering, latency, option bits |
| cmd_valid | input | 1 | Read or write command present |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_col | input | COL_W | Starting column of the command |
| burst_stop | input | 1 | Terminate the running burst |
| col_addr | output | COL_W | Column address of the current beat, 0 when idle |
| burst_active | output | 1 | A burst beat is being produced |
| last_beat | output | 1 | Current beat is the final one of a finite burst |
| cas_lat | output | 2 | Decoded CAS latency, 2 or 3 |
| mode_err | output | 1 | Last loaded mode word was illegal |

## Verification
Some properties are checked on every cycle. In incrementing bursts, each beat advances the in-block offset by one modulo the length, and the bits above the block never change in mid-burst. Further per-cycle checks confirm that a command always yields an active first beat at the commanded column, and that a final beat or a stop request drops the active flag. A full-page burst must also stay active while nothing interrupts it.

Other behaviour needs the bench's scenarios. The exact interleaved sequence for every start column and length is one example. Others are the decoding of each legal and illegal mode word, and single-beat writes next to full-length reads. The bench also covers interrupting a burst in mid-flight, command-over-stop priority, and a mode load during a running burst leaving that burst untouched.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int MODE_BITS = 12;
  localparam int LEN_LSB   = 0;
  localparam int ORD_BIT   = 3;
  localparam int CL_LSB    = 4;
  localparam int OPM_LSB   = 7;
  localparam int SWR_BIT   = 9;
  localparam int HI_LSB    = 10;

  typedef enum logic [1:0] {
    BL_1 = 2'd0,
    BL_2 = 2'd1,
    BL_4 = 2'd2,
    BL_8 = 2'd3
  } blen_e;

  typedef struct packed {
    blen_e blen;
    logic  full_page;
    logic  interleave;
    logic  cas3;
    logic  single_wr;
    logic  err;
  } mode_cfg_t;

  localparam mode_cfg_t MODE_RESET = '{blen: BL_1, full_page: 1'b0,
                                       interleave: 1'b0, cas3: 1'b0,
                                       single_wr: 1'b0, err: 1'b0};

  function automatic mode_cfg_t decode_mode(input logic [MODE_BITS-1:0] w);
    mode_cfg_t c;
    logic      bad;
    c            = MODE_RESET;
    bad          = 1'b0;
    c.interleave = w[ORD_BIT];
    c.single_wr  = w[SWR_BIT];
    case (w[LEN_LSB +: 3])
      3'b000: c.blen = BL_1;
      3'b001: c.blen = BL_2;
      3'b010: c.blen = BL_4;
      3'b011: c.blen = BL_8;
      3'b111: begin
        c.blen = BL_8;
        if (w[ORD_BIT]) bad = 1'b1;
        else            c.full_page = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    case (w[CL_LSB +: 3])
      3'b010:  c.cas3 = 1'b0;
      3'b011:  c.cas3 = 1'b1;
      default: begin
        c.cas3 = 1'b1;
        bad    = 1'b1;
      end
    endcase
    if ((w[OPM_LSB +: 2] != 2'b00) || (w[HI_LSB +: 2] != 2'b00)) bad = 1'b1;
    if (bad) begin
      c.blen      = BL_1;
      c.full_page = 1'b0;
      c.cas3      = 1'b1;
    end
    c.err = bad;
    return c;
  endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [MODE_BITS-1:0] word,
  output mode_cfg_t            cfg
);

  mode_cfg_t cfg_d;
  mode_cfg_t cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = decode_mode(word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= MODE_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  AST_RSV_LEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    load && (word[LEN_LSB +: 3] == 3'b100) |=> cfg_q.err && (cfg_q.blen == BL_1)) // R4
    else $error("reserved length code not flagged");

  AST_CL_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    load && (word == 12'h030) |=> cfg_q.cas3 && !cfg_q.err) // R3
    else $error("latency 3 not decoded");

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_cfg_t        cfg,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             stop,
  output logic             act,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] start,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic             endless,
  output logic             last
);

  localparam logic [COL_W-1:0] ONE_C  = COL_W'(1);
  localparam logic [COL_W-1:0] FULL_M = '1;

  logic             act_q, act_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] start_q, start_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             ilv_q, ilv_d;
  logic             endless_q, endless_d;
  logic             one_shot;
  logic [COL_W-1:0] cfg_mask;
  logic             at_end;

  always_comb begin
    cfg_mask = (ONE_C << cfg.blen) - ONE_C;
    if (cfg.full_page) cfg_mask = FULL_M;
  end

  assign one_shot = cmd_write && cfg.single_wr;
  assign at_end   = !endless_q && (beat_q == mask_q);

  always_comb begin
    act_d     = act_q;
    beat_d    = beat_q;
    start_d   = start_q;
    mask_d    = mask_q;
    ilv_d     = ilv_q;
    endless_d = endless_q;
    if (cmd_valid) begin
      act_d     = 1'b1;
      beat_d    = '0;
      start_d   = cmd_col;
      mask_d    = one_shot ? '0 : cfg_mask;
      ilv_d     = cfg.interleave;
      endless_d = cfg.full_page && !one_shot;
    end else if (stop) begin
      act_d  = 1'b0;
      beat_d = '0;
    end else if (act_q) begin
      if (at_end) begin
        act_d  = 1'b0;
        beat_d = '0;
      end else begin
        beat_d = beat_q + ONE_C;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      beat_q    <= '0;
      start_q   <= '0;
      mask_q    <= '0;
      ilv_q     <= 1'b0;
      endless_q <= 1'b0;
    end else begin
      act_q     <= act_d;
      beat_q    <= beat_d;
      start_q   <= start_d;
      mask_q    <= mask_d;
      ilv_q     <= ilv_d;
      endless_q <= endless_d;
    end
  end

  assign act     = act_q;
  assign beat    = beat_q;
  assign start   = start_q;
  assign mask    = mask_q;
  assign ilv     = ilv_q;
  assign endless = endless_q;
  assign last    = act_q && at_end;

  AST_CMD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> act_q && (beat_q == '0)) // R9
    else $error("command did not start a burst");

  AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    last && !cmd_valid |=> !act_q) // R8
    else $error("burst continued past final beat");

  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !cmd_valid |=> !act_q) // R10
    else $error("stop did not end burst");

  AST_FULL_PAGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && endless_q && !cmd_valid && !stop |=> act_q) // R7
    else $error("full page burst ended by itself");

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 8
) (
  input  logic             act,
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mapped;

  assign sum = start + beat;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask[b])  mapped[b] = start[b];
      else if (ilv)  mapped[b] = start[b] ^ beat[b];
      else           mapped[b] = sum[b];
    end
  end

  assign col = act ? mapped : '0;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_load,
  input  logic [MODE_BITS-1:0] mode_word,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [COL_W-1:0]     cmd_col,
  input  logic                 burst_stop,
  output logic [COL_W-1:0]     col_addr,
  output logic                 burst_active,
  output logic                 last_beat,
  output logic [1:0]           cas_lat,
  output logic                 mode_err
);

  mode_cfg_t        cfg;
  logic             act;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] start;
  logic [COL_W-1:0] mask;
  logic             ilv;
  logic             endless;
  logic             last;

  burst_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .word  (mode_word),
    .cfg   (cfg)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_col   (cmd_col),
    .stop      (burst_stop),
    .act       (act),
    .beat      (beat),
    .start     (start),
    .mask      (mask),
    .ilv       (ilv),
    .endless   (endless),
    .last      (last)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .act   (act),
    .start (start),
    .beat  (beat),
    .mask  (mask),
    .ilv   (ilv),
    .col   (col_addr)
  );

  assign burst_active = act;
  assign last_beat    = last;
  assign cas_lat      = cfg.cas3 ? 2'd3 : 2'd2;
  assign mode_err     = cfg.err;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active && $past(burst_active) && !$past(cmd_valid) && !ilv
    |-> ((col_addr & mask) == (($past(col_addr) + COL_W'(1)) & mask))) // R5
    else $error("incrementing order broke");

  AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active && $past(burst_active) && !$past(cmd_valid) && !endless
    |-> ((col_addr & ~mask) == ($past(col_addr) & ~mask))) // R6
    else $error("address left its block");

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> burst_active && (col_addr == $past(cmd_col))) // R9
    else $error("first beat not at commanded column");

endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

  localparam int COL_W = 8;

  logic             clk;
  logic             rst_n;
  logic             mode_load;
  logic [11:0]      mode_word;
  logic             cmd_valid;
  logic             cmd_write;
  logic [COL_W-1:0] cmd_col;
  logic             burst_stop;
  logic [COL_W-1:0] col_addr;
  logic             burst_active;
  logic             last_beat;
  logic [1:0]       cas_lat;
  logic             mode_err;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  sdram_burst_colgen #(.COL_W(COL_W)) u_sdram_burst_colgen (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_load    (mode_load),
    .mode_word    (mode_word),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_col      (cmd_col),
    .burst_stop   (burst_stop),
    .col_addr     (col_addr),
    .burst_active (burst_active),
    .last_beat    (last_beat),
    .cas_lat      (cas_lat),
    .mode_err     (mode_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung actual=%0d expected<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  function automatic int exp_addr(input int s, input int len, input bit il, input int i);
    int off;
    int base;
    off  = s % len;
    base = s - off;
    if (il) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  task automatic load_mode(input int w);
    @(negedge clk);
    mode_load = 1'b1;
    mode_word = 12'(w);
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic issue(input int col, input bit wr);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_col   = COL_W'(col);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
  endtask

  task automatic chk_beat(input int s, input int len, input bit il, input int i,
                          input string req);
    int e;
    e = exp_addr(s, len, il, i);
    chk(col_addr == COL_W'(e), req, "col_addr", col_addr, e);
    chk(burst_active == 1'b1, req, "burst_active", burst_active, 1);
    chk(last_beat == (i == len - 1), req, "last_beat", last_beat, (i == len - 1));
  endtask

  task automatic chk_idle(input string req);
    chk(burst_active == 1'b0, req, "burst_active idle", burst_active, 0);
    chk(col_addr == '0, req, "col_addr idle", col_addr, 0);
  endtask

  task automatic run_burst(input int s, input int len, input bit il, input string req);
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      chk_beat(s, len, il, i, req);
    end
    @(negedge clk);
    chk_idle(req);
  endtask

  initial begin
    rst_n      = 1'b0;
    mode_load  = 1'b0;
    mode_word  = '0;
    cmd_valid  = 1'b0;
    cmd_write  = 1'b0;
    cmd_col    = '0;
    burst_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R8 idle outputs, R3 default latency, R4 no error
    chk_idle("R8");
    chk(last_beat == 1'b0, "R8", "last_beat reset", last_beat, 0);
    chk(cas_lat == 2'd2, "R3", "cas_lat reset", cas_lat, 2);
    chk(mode_err == 1'b0, "R4", "mode_err reset", mode_err, 0);

    // Sweep: R1 length codes, R2 ordering, R5 incrementing, R6 interleaved, R8 end
    for (int lc = 0; lc < 4; lc++) begin
      for (int t = 0; t < 2; t++) begin
        load_mode(lc | (t << 3) | (2 << 4));
        chk(mode_err == 1'b0, "R1", "mode_err legal", mode_err, 0);
        for (int s = 0; s < 256; s++) begin
          issue(s, 1'b0);
          run_burst(s, 1 << lc, t[0], t ? "R6" : "R5");
        end
      end
    end

    // R3: latency decode
    load_mode(12'h030);
    chk(cas_lat == 2'd3, "R3", "cas_lat code 011", cas_lat, 3);
    load_mode(12'h020);
    chk(cas_lat == 2'd2, "R3", "cas_lat code 010", cas_lat, 2);

    // R7: full page wraps the row, never last, stopped by R10
    load_mode(12'h027);
    issue(250, 1'b0);
    for (int i = 0; i < 300; i++) begin
      if (i > 0) @(negedge clk);
      chk(col_addr == COL_W'((250 + i) % 256), "R7", "full page col", col_addr, (250 + i) % 256);
      chk(last_beat == 1'b0, "R7", "full page last", last_beat, 0);
      chk(burst_active == 1'b1, "R7", "full page active", burst_active, 1);
    end
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk_idle("R10");

    // R4: illegal words
    load_mode(12'h02F);
    chk(mode_err == 1'b1, "R4", "full page interleave err", mode_err, 1);
    chk(cas_lat == 2'd3, "R4", "cas_lat on err", cas_lat, 3);
    issue(37, 1'b0);
    run_burst(37, 1, 1'b0, "R4");
    load_mode(12'h024);
    chk(mode_err == 1'b1, "R4", "length 100 err", mode_err, 1);
    issue(90, 1'b0);
    run_burst(90, 1, 1'b0, "R4");
    load_mode(12'h002);
    chk(mode_err == 1'b1, "R4", "latency 000 err", mode_err, 1);
    issue(12, 1'b0);
    run_burst(12, 1, 1'b0, "R4");
    load_mode(12'h0A3);
    chk(mode_err == 1'b1, "R4", "operation bit err", mode_err, 1);
    load_mode(12'h423);
    chk(mode_err == 1'b1, "R4", "high bit err", mode_err, 1);
    load_mode(12'h023);
    chk(mode_err == 1'b0, "R4", "legal clears err", mode_err, 0);

    // R9: interrupt mid-burst restarts full length
    issue(5, 1'b0);
    chk_beat(5, 8, 1'b0, 0, "R9");
    @(negedge clk);
    chk_beat(5, 8, 1'b0, 1, "R9");
    @(negedge clk);
    chk_beat(5, 8, 1'b0, 2, "R9");
    cmd_valid = 1'b1;
    cmd_col   = 8'd20;
    @(negedge clk);
    cmd_valid = 1'b0;
    run_burst(20, 8, 1'b0, "R9");

    // R9: command beats stop at the same edge
    issue(40, 1'b0);
    chk_beat(40, 8, 1'b0, 0, "R9");
    cmd_valid  = 1'b1;
    burst_stop = 1'b1;
    cmd_col    = 8'd9;
    @(negedge clk);
    cmd_valid  = 1'b0;
    burst_stop = 1'b0;
    run_burst(9, 8, 1'b0, "R9");

    // R10: stop in the middle of a finite burst
    issue(100, 1'b0);
    chk_beat(100, 8, 1'b0, 0, "R10");
    @(negedge clk);
    chk_beat(100, 8, 1'b0, 1, "R10");
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk_idle("R10");

    // R11: single-beat writes, full-length reads
    load_mode(12'h222);
    issue(6, 1'b1);
    run_burst(6, 1, 1'b0, "R11");
    issue(6, 1'b0);
    run_burst(6, 4, 1'b0, "R11");
    load_mode(12'h022);
    issue(6, 1'b1);
    run_burst(6, 4, 1'b0, "R11");

    // R12: mode load during a burst leaves it unchanged
    load_mode(12'h023);
    issue(1, 1'b0);
    chk_beat(1, 8, 1'b0, 0, "R12");
    mode_load = 1'b1;
    mode_word = 12'h029;
    @(negedge clk);
    mode_load = 1'b0;
    for (int i = 1; i < 8; i++) begin
      if (i > 1) @(negedge clk);
      chk_beat(1, 8, 1'b0, i, "R12");
    end
    @(negedge clk);
    chk_idle("R12");
    issue(3, 1'b0);
    run_burst(3, 2, 1'b1, "R12");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule